// File: doc/BRIEF.md
# Row Activate Timing Guard

This block sits beside the command picker of a DRAM scheduler and decides, on every clock, whether a pending row-open (ACTIVATE) request may go to the memory in that cycle. A request names a bank group and a bank within that group. The block compares the request against its history of recent activates and raises a grant only when every spacing rule holds. The scheduler then pulses an issue strobe to commit the activate, and only then does the history change.

Two spacing rules govern consecutive activates. A short minimum gap applies between any two activates. A longer minimum gap applies between activates to the same bank group. A rolling window also limits the stream: no more than four activates may fall inside any window of a programmable length. The three limits arrive as runtime inputs counted in clock cycles. The block also tracks which banks hold an open row, because a bank with an open row cannot be activated again. A precharge input closes a bank again.

Top module: `act_spacing_guard`

## Requirements
- R1: A request is refused while fewer than `tRrdS` cycles have passed since the most recent accepted activate to any bank group. An activate accepted in cycle t allows a grant again from cycle t+tRrdS onwards.
- R2: A request is refused while fewer than `tRrdL` cycles have passed since the most recent accepted activate to the same bank group.
- R3: Once four activates have been accepted, a new request is refused until at least `tFaw` cycles have passed since the oldest of the last four.
- R4: The first four activates after reset can be accepted at the `tRrdS` spacing alone, provided the group rule is met.
- R5: A request to a bank whose row is open is refused. Requests to other banks are not affected by that open bank.
- R6: A precharge pulse (`preValid` with `preGroup`/`preBank`) closes that bank, so it can be granted again. When an accepted activate and a precharge hit the same bank in one cycle, the bank ends open.
- R7: After reset, no history limits a request and every bank is closed. The first request is granted at once, even with all timing inputs at their maximum.
- R8: `grant` is combinational on the current request and state, and it is low whenever `reqValid` is low.
- R9: An `issue` pulse in a cycle where `grant` is low is ignored. It changes no timing history and opens no bank.
- R10: An idle gap of any length never leaves a stale entry in the history that refuses a request; the timestamp counter wrapping cannot cause one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | An activate request is present |
| reqGroup | input | 2 | Bank group of the request |
| reqBank | input | 2 | Bank within the group |
| issue | input | 1 | Commit the requested activate (effective only with grant) |
| preValid | input | 1 | Close one bank this cycle |
| preGroup | input | 2 | Bank group to close |
| preBank | input | 2 | Bank to close |
| tRrdS | input | 8 | Minimum cycles between any two activates |
| tRrdL | input | 8 | Minimum cycles between activates to the same group |
| tFaw | input | 8 | Length of the four-activate window in cycles |
| grant | output | 1 | The request may be issued this cycle |

## Verification
On every cycle, embedded properties check three things. Any accepted activate respects the any-group and same-group spacing, measured by independent age counters. A bank just opened is never granted again on the next cycle. An issue without a grant leaves the stored history untouched. Other behaviours only the directed scenarios can show: the four-activate window opening on the exact cycle, the precharge reopening a bank, the set-over-clear order when an activate and a precharge meet, the state right after reset, and the absence of false refusals after a long idle gap.

// File: rtl/act_guard_pkg.sv
package act_guard_pkg;

  // Strobes from the control half to the datapath half.
  typedef struct packed {
    logic record;   // commit an accepted activate into the history
    logic close;    // close the bank named by the precharge inputs
  } actStrobe_t;

endpackage

// File: rtl/act_guard_dp.sv
module act_guard_dp
  import act_guard_pkg::*;
#(
  parameter int NUM_GROUPS      = 4,
  parameter int BANKS_PER_GROUP = 4,
  parameter int TIME_W          = 8,
  parameter int WINDOW_ACTS     = 4,
  localparam int GW = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
  localparam int BW = (BANKS_PER_GROUP > 1) ? $clog2(BANKS_PER_GROUP) : 1,
  localparam int CW = TIME_W + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  actStrobe_t    strobe,
  input  logic [GW-1:0] reqGroup,
  input  logic [BW-1:0] reqBank,
  input  logic [GW-1:0] preGroup,
  input  logic [BW-1:0] preBank,
  output logic [CW-1:0] globalAge,
  output logic          globalValid,
  output logic [CW-1:0] groupAge,
  output logic          groupValid,
  output logic [CW-1:0] oldestAge,
  output logic          windowFull,
  output logic          bankOpen
);

  localparam int NB = NUM_GROUPS * BANKS_PER_GROUP;
  localparam int PW = (WINDOW_ACTS > 1) ? $clog2(WINDOW_ACTS) : 1;

  logic [CW-1:0] now;
  logic [CW-1:0] lastStamp;
  logic          lastValid;
  logic [CW-1:0] grpStamp [NUM_GROUPS];
  logic [NUM_GROUPS-1:0] grpValid;
  logic [CW-1:0] winStamp [WINDOW_ACTS];
  logic [WINDOW_ACTS-1:0] winValid;
  logic [PW-1:0] wrPtr;
  logic [NB-1:0] openRow;

  int reqIdx, preIdx;
  always_comb begin
    reqIdx = int'(reqGroup) * BANKS_PER_GROUP + int'(reqBank);
    preIdx = int'(preGroup) * BANKS_PER_GROUP + int'(preBank);
  end

  // Free-running cycle count used as the timestamp base.
  always_ff @(posedge clk) begin
    if (!rstN) now <= '0;
    else       now <= now + 1'b1;
  end

  // Most recent activate to any group; an entry goes stale once its age
  // reaches 2**TIME_W, which no timing input can exceed.
  logic [CW-1:0] lastAgeRaw;
  assign lastAgeRaw = now - lastStamp;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastStamp <= '0;
      lastValid <= 1'b0;
    end else if (strobe.record) begin
      lastStamp <= now;
      lastValid <= 1'b1;
    end else if (lastAgeRaw[CW-1]) begin
      lastValid <= 1'b0;
    end
  end

  // Per-group last activate.
  generate
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      logic [CW-1:0] ageRaw;
      assign ageRaw = now - grpStamp[g];
      always_ff @(posedge clk) begin
        if (!rstN) begin
          grpStamp[g] <= '0;
          grpValid[g] <= 1'b0;
        end else if (strobe.record && int'(reqGroup) == g) begin
          grpStamp[g] <= now;
          grpValid[g] <= 1'b1;
        end else if (ageRaw[CW-1]) begin
          grpValid[g] <= 1'b0;
        end
      end
    end
  endgenerate

  // Circular record of the last WINDOW_ACTS activates.
  always_ff @(posedge clk) begin
    if (!rstN)              wrPtr <= '0;
    else if (strobe.record) wrPtr <= (int'(wrPtr) == WINDOW_ACTS - 1) ? '0 : wrPtr + 1'b1;
  end

  generate
    for (genvar w = 0; w < WINDOW_ACTS; w++) begin : g_win
      logic [CW-1:0] ageRaw;
      assign ageRaw = now - winStamp[w];
      always_ff @(posedge clk) begin
        if (!rstN) begin
          winStamp[w] <= '0;
          winValid[w] <= 1'b0;
        end else if (strobe.record && int'(wrPtr) == w) begin
          winStamp[w] <= now;
          winValid[w] <= 1'b1;
        end else if (ageRaw[CW-1]) begin
          winValid[w] <= 1'b0;
        end
      end
    end
  endgenerate

  // Open-row flags: an accepted activate sets, a precharge clears, set wins.
  generate
    for (genvar b = 0; b < NB; b++) begin : g_bank
      always_ff @(posedge clk) begin
        if (!rstN)                              openRow[b] <= 1'b0;
        else if (strobe.record && reqIdx == b)  openRow[b] <= 1'b1;
        else if (strobe.close && preIdx == b)   openRow[b] <= 1'b0;
      end
    end
  endgenerate

  always_comb begin
    globalAge   = lastAgeRaw;
    globalValid = lastValid;
    groupAge    = now - grpStamp[reqGroup];
    groupValid  = grpValid[reqGroup];
    oldestAge   = now - winStamp[wrPtr];
    windowFull  = &winValid;
    bankOpen    = openRow[reqIdx];
  end

  // R9: without a commit strobe the stored stamps stay where they were.
  a_r9_no_update : assert property (@(posedge clk) disable iff (!rstN)
    !strobe.record |=> ($stable(lastStamp) && $stable(wrPtr)));

endmodule

// File: rtl/act_guard_ctrl.sv
module act_guard_ctrl
  import act_guard_pkg::*;
#(
  parameter int TIME_W = 8,
  localparam int CW = TIME_W + 1
) (
  input  logic              reqValid,
  input  logic              issue,
  input  logic              preValid,
  input  logic [TIME_W-1:0] tRrdS,
  input  logic [TIME_W-1:0] tRrdL,
  input  logic [TIME_W-1:0] tFaw,
  input  logic [CW-1:0]     globalAge,
  input  logic              globalValid,
  input  logic [CW-1:0]     groupAge,
  input  logic              groupValid,
  input  logic [CW-1:0]     oldestAge,
  input  logic              windowFull,
  input  logic              bankOpen,
  output logic              grant,
  output actStrobe_t        strobe
);

  logic shortOk, longOk, windowOk;

  always_comb begin
    shortOk  = !globalValid || (globalAge >= {1'b0, tRrdS});
    longOk   = !groupValid  || (groupAge  >= {1'b0, tRrdL});
    windowOk = !windowFull  || (oldestAge >= {1'b0, tFaw});
    grant    = reqValid && !bankOpen && shortOk && longOk && windowOk;
    strobe.record = issue && grant;
    strobe.close  = preValid;
  end

endmodule

// File: rtl/act_spacing_guard.sv
module act_spacing_guard
  import act_guard_pkg::*;
#(
  parameter int NUM_GROUPS      = 4,
  parameter int BANKS_PER_GROUP = 4,
  parameter int TIME_W          = 8,
  parameter int WINDOW_ACTS     = 4,
  localparam int GW = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
  localparam int BW = (BANKS_PER_GROUP > 1) ? $clog2(BANKS_PER_GROUP) : 1,
  localparam int CW = TIME_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [GW-1:0]     reqGroup,
  input  logic [BW-1:0]     reqBank,
  input  logic              issue,
  input  logic              preValid,
  input  logic [GW-1:0]     preGroup,
  input  logic [BW-1:0]     preBank,
  input  logic [TIME_W-1:0] tRrdS,
  input  logic [TIME_W-1:0] tRrdL,
  input  logic [TIME_W-1:0] tFaw,
  output logic              grant
);

  actStrobe_t    strobe;
  logic [CW-1:0] globalAge, groupAge, oldestAge;
  logic          globalValid, groupValid, windowFull, bankOpen;

  act_guard_ctrl #(.TIME_W(TIME_W)) u_ctrl (
    .reqValid(reqValid), .issue(issue), .preValid(preValid),
    .tRrdS(tRrdS), .tRrdL(tRrdL), .tFaw(tFaw),
    .globalAge(globalAge), .globalValid(globalValid),
    .groupAge(groupAge), .groupValid(groupValid),
    .oldestAge(oldestAge), .windowFull(windowFull),
    .bankOpen(bankOpen), .grant(grant), .strobe(strobe)
  );

  act_guard_dp #(
    .NUM_GROUPS(NUM_GROUPS), .BANKS_PER_GROUP(BANKS_PER_GROUP),
    .TIME_W(TIME_W), .WINDOW_ACTS(WINDOW_ACTS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .reqGroup(reqGroup), .reqBank(reqBank),
    .preGroup(preGroup), .preBank(preBank),
    .globalAge(globalAge), .globalValid(globalValid),
    .groupAge(groupAge), .groupValid(groupValid),
    .oldestAge(oldestAge), .windowFull(windowFull),
    .bankOpen(bankOpen)
  );

  // Independent saturating age counters, seen only by the assertions.
  logic          accept;
  logic [CW-1:0] sinceAny;
  logic          anySeen;
  logic [CW-1:0] sinceGrp [NUM_GROUPS];
  logic [NUM_GROUPS-1:0] grpSeen;

  assign accept = issue && grant;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceAny <= '0;
      anySeen  <= 1'b0;
    end else if (accept) begin
      sinceAny <= CW'(1);
      anySeen  <= 1'b1;
    end else if (!sinceAny[CW-1]) begin
      sinceAny <= sinceAny + 1'b1;
    end
  end

  generate
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_chk
      always_ff @(posedge clk) begin
        if (!rstN) begin
          sinceGrp[g] <= '0;
          grpSeen[g]  <= 1'b0;
        end else if (accept && int'(reqGroup) == g) begin
          sinceGrp[g] <= CW'(1);
          grpSeen[g]  <= 1'b1;
        end else if (!sinceGrp[g][CW-1]) begin
          sinceGrp[g] <= sinceGrp[g] + 1'b1;
        end
      end
    end
  endgenerate

  a_r1_short_gap : assert property (@(posedge clk) disable iff (!rstN)
    (accept && anySeen) |-> (sinceAny >= {1'b0, tRrdS}));

  a_r2_long_gap : assert property (@(posedge clk) disable iff (!rstN)
    (accept && grpSeen[reqGroup]) |-> (sinceGrp[reqGroup] >= {1'b0, tRrdL}));

  a_r5_open_bank : assert property (@(posedge clk) disable iff (!rstN)
    accept |=> !(grant && reqGroup == $past(reqGroup) && reqBank == $past(reqBank)));

endmodule

// File: tb/act_spacing_guard_bench.sv
module act_spacing_guard_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic [1:0] reqGroup = '0;
  logic [1:0] reqBank = '0;
  logic       issue = 1'b0;
  logic       preValid = 1'b0;
  logic [1:0] preGroup = '0;
  logic [1:0] preBank = '0;
  logic [7:0] tRrdS = 8'd2;
  logic [7:0] tRrdL = 8'd5;
  logic [7:0] tFaw = 8'd12;
  logic       grant;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  act_spacing_guard u_act_spacing_guard (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqGroup(reqGroup),
    .reqBank(reqBank), .issue(issue), .preValid(preValid),
    .preGroup(preGroup), .preBank(preBank), .tRrdS(tRrdS),
    .tRrdL(tRrdL), .tFaw(tFaw), .grant(grant)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: grant=%0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic doReset(input logic [7:0] s, input logic [7:0] l, input logic [7:0] f);
    @(negedge clk);
    rstN = 1'b0; reqValid = 1'b0; issue = 1'b0; preValid = 1'b0;
    tRrdS = s; tRrdL = l; tFaw = f;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  // One cycle: present a request with issue high, check grant before the edge.
  task automatic tryAct(input int g, input int b, input logic exp, input string tag);
    @(negedge clk);
    reqValid = 1'b1; reqGroup = 2'(g); reqBank = 2'(b); issue = 1'b1; preValid = 1'b0;
    #1 check(tag, grant, exp);
  endtask

  // Same, with a precharge to the same bank in the same cycle.
  task automatic tryWithClose(input int g, input int b, input logic exp, input string tag);
    @(negedge clk);
    reqValid = 1'b1; reqGroup = 2'(g); reqBank = 2'(b); issue = 1'b1;
    preValid = 1'b1; preGroup = 2'(g); preBank = 2'(b);
    #1 check(tag, grant, exp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      reqValid = 1'b0; issue = 1'b0; preValid = 1'b0;
    end
  endtask

  task automatic closeBank(input int g, input int b);
    @(negedge clk);
    reqValid = 1'b0; issue = 1'b0;
    preValid = 1'b1; preGroup = 2'(g); preBank = 2'(b);
  endtask

  task automatic testResetState();
    doReset(8'd255, 8'd255, 8'd255);
    @(negedge clk);
    reqValid = 1'b0; reqGroup = 2'd3; reqBank = 2'd3; issue = 1'b1;
    #1 check("R8 no request", grant, 1'b0);
    tryAct(3, 3, 1'b1, "R7 first grant");
    tryAct(3, 2, 1'b0, "R2 max spacing");
    idle(1);
  endtask

  // Spacing and window, with tRrdS=2 tRrdL=5 tFaw=12; cycle numbers in comments.
  task automatic testSpacingWindow();
    doReset(8'd2, 8'd5, 8'd12);
    tryAct(0, 0, 1'b1, "R7 after reset");      // 0 accepted
    tryAct(1, 0, 1'b0, "R1 gap 1");            // 1 refused, issue ignored
    tryAct(1, 0, 1'b1, "R1 R9 gap 2");         // 2 accepted
    tryAct(0, 1, 1'b0, "R1 other group gap 1");// 3
    tryAct(0, 1, 1'b0, "R2 same group gap 4"); // 4
    tryAct(0, 1, 1'b1, "R2 same group gap 5"); // 5 accepted
    idle(1);                                   // 6
    tryAct(2, 0, 1'b1, "R4 fourth at short gap"); // 7 accepted
    idle(1);                                   // 8
    tryAct(3, 0, 1'b0, "R3 window age 9");     // 9
    tryAct(3, 0, 1'b0, "R3 window age 10");    // 10
    tryAct(3, 0, 1'b0, "R3 window age 11");    // 11
    tryAct(3, 0, 1'b1, "R3 window age 12");    // 12 accepted
    tryAct(1, 1, 1'b0, "R3 R1 gap 1");         // 13
    tryAct(1, 1, 1'b1, "R3 window slides");    // 14 accepted
  endtask

  task automatic testOpenRows();
    idle(20);
    tryAct(0, 0, 1'b0, "R5 open bank");
    tryAct(0, 2, 1'b1, "R5 other bank");
    idle(20);
    closeBank(0, 0);
    tryAct(0, 0, 1'b1, "R6 reopened after precharge");
    idle(20);
    tryWithClose(1, 2, 1'b1, "R6 same-cycle grant");
    idle(20);
    tryAct(1, 2, 1'b0, "R6 activate beats precharge");
    idle(1);
  endtask

  task automatic testLongIdle();
    doReset(8'd255, 8'd255, 8'd255);
    tryAct(2, 0, 1'b1, "R10 first");
    tryAct(2, 1, 1'b0, "R10 still spaced");
    idle(600);
    tryAct(2, 1, 1'b1, "R10 after long idle");
    tryAct(2, 2, 1'b0, "R10 fresh history");
    idle(1);
  endtask

  initial begin
    testResetState();
    testSpacingWindow();
    testOpenRows();
    testLongIdle();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      finished = 1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule